// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

A single-port synchronous static memory, 32 bits wide in four byte lanes, with a parameterized number of words. Every control and data input is registered on the rising clock edge. Reads are flow-through: once an address has been captured, the word stored there appears on the read port within that same clock period, with no output register in between. Bursts of four beats are started by either of two address strobes. A 2-bit beat counter then generates the next three addresses, in either an interleaved or a linear order.

The two strobes behave differently. The host strobe wins when both are active. It only counts while the primary chip enable is asserted, and it always starts a read, whatever the write controls say. The controller strobe starts a read or a write, depending on the write controls sampled with it. Three chip enables of mixed polarity must all agree for the device to be selected. A global write lane override takes precedence over per-lane write enables. An asynchronous output enable and an asynchronous sleep input gate the read port. Sleep also turns every clocked cycle into a deselect cycle, and the stored contents are kept through it.

Top module: `fts_sram`

## Requirements
- R1: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A burst start seen with any other combination is a deselect cycle. After it the read port stops driving (`rdata_oe`=0), and no later cycle writes until a new burst start.
- R2: `host_start_n`=0 sampled with `sel_a_n`=0 starts a read burst at `addr`. The write controls are ignored on that cycle, and it has priority over `ctl_start_n`. With `sel_a_n`=1, `host_start_n` has no effect and `ctl_start_n` decides the cycle.
- R3: `ctl_start_n`=0 on a selected device starts a burst at `addr`. The burst is a write when `wr_all_n`=0, or when `wr_bytes_n`=0 with at least one `lane_wr_n` bit at 0. Otherwise it is a read.
- R4: On a write cycle, `wr_all_n`=0 writes all four lanes. Otherwise only lane i (bits 8i+7..8i) is written, and only when `wr_bytes_n`=0 and `lane_wr_n[i]`=0. Lanes that are not written keep their old value.
- R5: Reads are flow-through. After the edge that captures a read address, `rdata` equals the stored word at that address during the same clock period. In a read-then-write sequence it reflects the stored contents before the edge.
- R6: With `burst_linear`=0, beat k of a burst (k=0..3) uses address bits [1:0] = first[1:0] XOR k. The upper bits are kept.
- R7: With `burst_linear`=1, beat k uses address bits [1:0] = (first[1:0] + k) mod 4.
- R8: When neither strobe starts a cycle, `step_n`=0 advances the beat counter by one (wrapping after four beats) and continues the current read or write burst. `step_n`=1 keeps the current address. A continued write burst writes the lanes selected by R4 for that cycle.
- R9: `out_en_n`=1 forces `rdata_oe`=0 and `rdata`=0 at once, without waiting for a clock edge. It does not change the beat sequence.
- R10: `sleep`=1 forces `rdata_oe`=0 at once. Every clock edge taken while it is high is a deselect cycle with no write. The stored contents are kept across sleep.
- R11: When the read port is not driving, `rdata` is 0. It drives only during a selected read burst, with `out_en_n`=0 and `sleep`=0.
- R12: After reset (`rst_n`=0) no burst is active and `rdata_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the burst state |
| sleep | input | 1 | Asynchronous low-power request; contents retained |
| burst_linear | input | 1 | Beat order: 1 linear, 0 interleaved |
| sel_a_n | input | 1 | Primary chip enable, active low; also qualifies the host strobe |
| sel_b | input | 1 | Expansion chip enable, active high |
| sel_c_n | input | 1 | Expansion chip enable, active low |
| host_start_n | input | 1 | Host address strobe, read-only burst start, top priority |
| ctl_start_n | input | 1 | Controller address strobe, read or write burst start |
| step_n | input | 1 | Advance burst counter when low |
| wr_all_n | input | 1 | Write all lanes when low |
| wr_bytes_n | input | 1 | Enable per-lane writes when low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| out_en_n | input | 1 | Asynchronous read port enable, active low |
| rdata | output | DW | Flow-through read data, 0 when not driving |
| rdata_oe | output | 1 | High while the read port drives |

## Verification
The hardest cases to reach from the ports are the ones that only show up later, through a read. Examples are a mid-burst deselect followed by continuation cycles whose write controls are still asserted, or a write attempt while sleeping. These leave no trace until the affected words are read back. The directed stimulus first fills the whole array through write bursts, so every later read has a known value. It then runs each interference case against words with distinct contents and reads them back. After that, constrained random cycles mix strobes, partial selects, sleep and lane masks, and each cycle is compared with the bench's own array model.

// File: rtl/fts_pkg.sv
package fts_pkg;

  // Low two address bits for beat number cnt of a burst that began at first.
  function automatic logic [1:0] beat_offset(input logic [1:0] first,
                                             input logic [1:0] cnt,
                                             input logic       linear);
    logic [1:0] sum;
    sum = first + cnt;
    return linear ? sum : (first ^ cnt);
  endfunction

  // Selection needs all three enables in their active state.
  function automatic logic chip_selected(input logic a_n, input logic b,
                                         input logic c_n);
    return !a_n && b && !c_n;
  endfunction

endpackage

// File: rtl/fts_decode.sv
module fts_decode #(
  parameter int LANES = 4
) (
  input  logic             sleep,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             host_start_n,
  input  logic             ctl_start_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             cur_active,
  input  logic             cur_is_rd,
  output logic             go_start,
  output logic             go_deselect,
  output logic             go_adv,
  output logic             start_is_wr,
  output logic             cont_write,
  output logic [LANES-1:0] lane_sel
);
  import fts_pkg::*;

  logic chip_sel, host_hit, ctl_hit, any_start, cont;

  always_comb begin
    chip_sel  = chip_selected(sel_a_n, sel_b, sel_c_n);
    host_hit  = !host_start_n && !sel_a_n;
    ctl_hit   = !ctl_start_n && !host_hit;
    any_start = host_hit || ctl_hit;

    if (!wr_all_n)        lane_sel = '1;
    else if (!wr_bytes_n) lane_sel = ~lane_wr_n;
    else                  lane_sel = '0;

    go_start    = !sleep && any_start && chip_sel;
    go_deselect = sleep || (any_start && !chip_sel);
    start_is_wr = ctl_hit && (|lane_sel);
    cont        = !sleep && !any_start && cur_active;
    go_adv      = cont && !step_n;
    cont_write  = cont && !cur_is_rd;
  end
endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_start,
  input  logic          go_deselect,
  input  logic          go_adv,
  input  logic          start_is_wr,
  input  logic          linear,
  input  logic [AW-1:0] ext_addr,
  output logic          active,
  output logic          is_rd,
  output logic [1:0]    cnt,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  import fts_pkg::*;

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_d;

  always_comb begin
    base_d = go_start ? ext_addr : base_q;
    if (go_start)    cnt_d = 2'd0;
    else if (go_adv) cnt_d = cnt + 2'd1;
    else             cnt_d = cnt;
    nxt_addr = {base_d[AW-1:2], beat_offset(base_d[1:0], cnt_d, linear)};
    cur_addr = {base_q[AW-1:2], beat_offset(base_q[1:0], cnt, linear)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_rd  <= 1'b1;
      cnt    <= 2'd0;
      base_q <= '0;
    end else begin
      base_q <= base_d;
      cnt    <= cnt_d;
      if (go_start) begin
        active <= 1'b1;
        is_rd  <= !start_is_wr;
      end else if (go_deselect) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] we_lanes,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (we_lanes[l]) store[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rdata[l*LANE_W +: LANE_W] = store[raddr];
  end
endmodule

// File: rtl/fts_sram.sv
module fts_sram #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             burst_linear,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             host_start_n,
  input  logic             ctl_start_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             out_en_n,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);
  // Named internal events, observed by the bound checker.
  logic             go_start, go_deselect, adv_now, start_is_wr, cont_write;
  logic             write_now, rd_live, burst_active, burst_is_rd;
  logic [LANES-1:0] lane_sel, wr_lanes;
  logic [1:0]       burst_cnt;
  logic [AW-1:0]    cur_addr, nxt_addr;
  logic [DW-1:0]    array_q;

  fts_decode #(.LANES(LANES)) u_decode (
    .sleep(sleep), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .host_start_n(host_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n), .lane_wr_n(lane_wr_n),
    .cur_active(burst_active), .cur_is_rd(burst_is_rd),
    .go_start(go_start), .go_deselect(go_deselect), .go_adv(adv_now),
    .start_is_wr(start_is_wr), .cont_write(cont_write), .lane_sel(lane_sel)
  );

  fts_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_start(go_start), .go_deselect(go_deselect),
    .go_adv(adv_now), .start_is_wr(start_is_wr), .linear(burst_linear),
    .ext_addr(addr), .active(burst_active), .is_rd(burst_is_rd),
    .cnt(burst_cnt), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  assign write_now = (go_start && start_is_wr) || cont_write;
  assign wr_lanes  = write_now ? lane_sel : '0;

  fts_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we_lanes(wr_lanes), .waddr(nxt_addr), .wdata(wdata),
    .raddr(cur_addr), .rdata(array_q)
  );

  assign rd_live  = burst_active && burst_is_rd;
  assign rdata_oe = rd_live && !out_en_n && !sleep;
  assign rdata    = rdata_oe ? array_q : '0;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             host_start_n,
  input logic             ctl_start_n,
  input logic             wr_all_n,
  input logic             out_en_n,
  input logic             rdata_oe,
  input logic             adv_now,
  input logic [1:0]       burst_cnt,
  input logic [LANES-1:0] wr_lanes
);
  logic sel_ok, host_hit, any_start;
  assign sel_ok    = !sel_a_n && sel_b && !sel_c_n;
  assign host_hit  = !host_start_n && !sel_a_n;
  assign any_start = host_hit || !ctl_start_n;

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (any_start && !sel_ok) |=> !rdata_oe);

  assert_host_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_hit |-> (wr_lanes == '0));

  assert_global_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_hit && !ctl_start_n && sel_ok && !sleep && !wr_all_n) |-> (&wr_lanes));

  assert_step_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_now |=> (burst_cnt == $past(burst_cnt) + 2'd1));

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_oe);

  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rdata_oe && wr_lanes == '0));
endmodule

bind fts_sram fts_sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_a_n(sel_a_n), .sel_b(sel_b),
  .sel_c_n(sel_c_n), .host_start_n(host_start_n), .ctl_start_n(ctl_start_n),
  .wr_all_n(wr_all_n), .out_en_n(out_en_n), .rdata_oe(rdata_oe),
  .adv_now(adv_now), .burst_cnt(burst_cnt), .wr_lanes(wr_lanes)
);

// File: tb/fts_sram_tb.sv
`timescale 1ns/1ps
module fts_sram_tb;
  localparam int AW = 8, LANES = 4, LW = 8, DW = 32, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep, burst_linear, sel_a_n, sel_b, sel_c_n, host_start_n, ctl_start_n;
  logic step_n, wr_all_n, wr_bytes_n, out_en_n;
  logic [LANES-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic rdata_oe;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // Bench reference state.
  logic [DW-1:0] ref_mem [DEPTH];
  bit            m_active = 0, m_rd = 1;
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;

  always #2 clk = ~clk;

  fts_sram u_dut (.*);

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, int k, bit lin);
    int lo = b % 4;
    int off = lin ? (lo + k) % 4 : (lo ^ k);
    return (b & ~AW'(3)) | AW'(off);
  endfunction

  function automatic logic [LANES-1:0] lanes_now();
    logic [LANES-1:0] m = '0;
    for (int i = 0; i < LANES; i++)
      m[i] = !wr_all_n || (!wr_bytes_n && !lane_wr_n[i]);
    return m;
  endfunction

  task automatic ref_write(logic [AW-1:0] a, logic [LANES-1:0] m);
    for (int i = 0; i < LANES; i++)
      if (m[i]) ref_mem[a][i*LW +: LW] = wdata[i*LW +: LW];
  endtask

  // Applied right after each rising edge, from the inputs held across it.
  task automatic model_edge();
    bit sel = !sel_a_n && sel_b && !sel_c_n;
    bit hhit = !host_start_n && !sel_a_n;
    if (sleep) m_active = 0;
    else if (hhit || !ctl_start_n) begin
      if (!sel) m_active = 0;
      else begin
        m_active = 1; m_base = addr; m_beat = 0;
        m_rd = hhit || (lanes_now() == '0);
        if (!m_rd) ref_write(addr, lanes_now());
      end
    end else if (m_active) begin
      if (!step_n) m_beat = (m_beat + 1) % 4;
      if (!m_rd) ref_write(beat_addr(m_base, m_beat, burst_linear), lanes_now());
    end
  endtask

  task automatic compare(string req);
    bit e_oe = m_active && m_rd && !out_en_n && !sleep;
    logic [DW-1:0] e_d = e_oe ? ref_mem[beat_addr(m_base, m_beat, burst_linear)] : '0;
    n_cmp++;
    if (rdata_oe !== e_oe || rdata !== e_d) begin
      n_bad++;
      $display("FAIL %s: oe=%0b data=%08h expected oe=%0b data=%08h",
               req, rdata_oe, rdata, e_oe, e_d);
    end
  endtask

  task automatic tick(string req);
    @(posedge clk); #0.1; model_edge();
    @(negedge clk); compare(req);
  endtask

  task automatic idle();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0; host_start_n = 1; ctl_start_n = 1;
    step_n = 1; wr_all_n = 1; wr_bytes_n = 1; lane_wr_n = '1; out_en_n = 0;
  endtask

  task automatic start_write(logic [AW-1:0] a, logic [DW-1:0] d, string req);
    idle(); ctl_start_n = 0; wr_all_n = 0; addr = a; wdata = d; tick(req);
  endtask

  task automatic start_host_read(logic [AW-1:0] a, string req);
    idle(); host_start_n = 0; addr = a; wr_all_n = 0; wr_bytes_n = 0; lane_wr_n = '0;
    tick(req);
  endtask

  task automatic step(string req);
    idle(); step_n = 0; tick(req);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++; $display("FAIL watchdog: expired, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(); sleep = 0; burst_linear = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    compare("R12 reset");
    rst_n = 1; @(negedge clk); compare("R12 idle after reset");

    // Fill every word through four-beat write bursts (R3, R4, R8).
    for (int b = 0; b < DEPTH / 4; b++) begin
      start_write(AW'(b * 4), $urandom, "R3 write start");
      for (int k = 0; k < 3; k++) begin
        idle(); step_n = 0; wr_all_n = 0; wdata = $urandom; tick("R8 write beat");
      end
    end

    // Interleaved read from offset 2, ignoring write controls (R2, R5, R6).
    burst_linear = 0;
    start_host_read(AW'(8'h46), "R2 host read ignores writes");
    for (int k = 0; k < 4; k++) step("R6 interleaved beat");
    // Linear from offset 3 (R7).
    burst_linear = 1;
    start_host_read(AW'(8'h13), "R5 flow-through first beat");
    for (int k = 0; k < 3; k++) step("R7 linear beat");
    // Host strobe with sel_a_n high is ignored: burst continues (R2).
    idle(); sel_a_n = 1; host_start_n = 0; step_n = 0; addr = 8'h80; tick("R2 host ignored");
    // Hold address (R8).
    idle(); tick("R8 hold"); idle(); tick("R8 hold again");

    // Lane-masked write then read back (R4); bwe low with no lanes reads (R3).
    burst_linear = 0;
    idle(); ctl_start_n = 0; wr_bytes_n = 0; lane_wr_n = 4'b1010; addr = 8'h20;
    wdata = 32'hA1B2C3D4; tick("R4 lane mask write");
    idle(); ctl_start_n = 0; wr_bytes_n = 0; lane_wr_n = 4'b1111; addr = 8'h20;
    wdata = 32'hFFFFFFFF; tick("R3 no-lane start reads");
    // Host and controller together: host wins, read (R2).
    idle(); host_start_n = 0; ctl_start_n = 0; wr_all_n = 0; addr = 8'h21; tick("R2 priority");

    // Output enable gates asynchronously, sequence goes on (R9).
    out_en_n = 1; #0.5 compare("R9 oe async off");
    idle(); out_en_n = 1; step_n = 0; tick("R9 oe off step");
    idle(); tick("R9 oe back, advanced");

    // Deselect mid-write-burst; continuation writes dropped (R1, R11).
    start_write(AW'(8'h30), 32'h11112222, "R1 write start");
    idle(); ctl_start_n = 0; sel_b = 0; addr = 8'h30; tick("R1 deselect");
    for (int k = 0; k < 3; k++) begin
      idle(); step_n = 0; wr_all_n = 0; wdata = 32'hDEADBEEF; tick("R11 no drive");
    end
    start_host_read(AW'(8'h30), "R1 readback");
    for (int k = 0; k < 3; k++) step("R1 readback beat");

    // Sleep in mid read burst, write attempt, retention (R10).
    start_host_read(AW'(8'h34), "R10 before sleep");
    sleep = 1; #0.5 compare("R10 async off");
    idle(); ctl_start_n = 0; wr_all_n = 0; addr = 8'h34; wdata = 32'h0; tick("R10 asleep write");
    idle(); step_n = 0; tick("R10 asleep step");
    sleep = 0;
    start_host_read(AW'(8'h34), "R10 retained");
    for (int k = 0; k < 3; k++) step("R10 retained beat");

    // Constrained random traffic.
    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 0) burst_linear = $urandom_range(0, 1);
      sel_a_n      = ($urandom_range(0, 99) < 8);
      sel_b        = ($urandom_range(0, 99) > 6);
      sel_c_n      = ($urandom_range(0, 99) < 6);
      host_start_n = ($urandom_range(0, 99) > 12);
      ctl_start_n  = ($urandom_range(0, 99) > 20);
      step_n       = ($urandom_range(0, 99) > 70);
      wr_all_n     = ($urandom_range(0, 99) > 20);
      wr_bytes_n   = ($urandom_range(0, 99) > 45);
      lane_wr_n    = LANES'($urandom);
      out_en_n     = ($urandom_range(0, 99) < 10);
      sleep        = ($urandom_range(0, 99) < 3);
      addr         = AW'($urandom);
      wdata        = $urandom;
      tick("R5 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule